// File: doc/BRIEF.md
# Single-Wire ROM Command Stage

This block is the addressing stage of a slave on a single-wire bus. A bit-level link layer below it turns line activity into three kinds of event: a bus reset, a received bit (the master wrote a slot), and a read request (the master opened a slot to be answered). After every bus reset the block collects one command byte. It then reads out, compares or arbitrates a 64-bit identity, or it skips addressing. When the command has finished, it raises `selected` so that the memory command controller above it may run.

The identity is assembled from a family-code parameter, a serial number taken from a port, and a CRC byte that logic computes from the first two parts. The block returns `tx_bit`, which is the value to drive during the next read slot. A 0 means pull the line low. A 1 means leave the line released, so several slaves answering at once combine as a wired-AND. `tx_bit` depends only on registered state. The link layer samples it when a read slot opens and pulses `rd_req` for one clock to consume it.

Top module: `rom_net_layer`

## Requirements
- R1: After a bus reset the block shifts in exactly eight received bits as a command byte, first bit into bit 0. Only the complete byte is decoded: 33h reads the identity, 55h matches it, F0h searches and CCh skips addressing.
- R2: Identity bit i is sent in read slot i, for i from 0 to 63. Bits 0 to 7 carry the family code (default 09h, bit 0 first), bits 8 to 55 carry `serial_num` (bit 0 first) and bits 56 to 63 carry the CRC byte. `selected` rises after the 64th read.
- R3: The CRC byte is computed from identity bits 0 to 55, taken in order, with polynomial x^8+x^5+x^4+1. The accumulator starts at zero and shifts right, and each step XORs in 8Ch when the outgoing accumulator bit differs from the input bit. The CRC follows changes of `serial_num`.
- R4: Under 55h, 64 received bits are compared in order with identity bits 0 to 63. If all of them agree, `selected` rises after the last one. The first mismatch makes the block silent until the next bus reset.
- R5: Under F0h, each identity bit takes three slots: a read that answers the bit, a read that answers its complement, and a received bit. If the received bit equals the identity bit, the block moves to the next position, and it selects after position 63. If it differs, the block goes silent until the next bus reset.
- R6: Under CCh, `selected` rises in the clock after the eighth command bit, with no identity transfer.
- R7: Any other command byte makes the block silent: `selected` stays 0, every read answers 1, and later received bits are ignored until a bus reset.
- R8: A bus reset takes priority over any event in the same cycle. It aborts any command, clears `selected` and restarts command reception.
- R9: Every read that does not carry identity data answers 1. This covers command reception, match, silence and the selected state.
- R10: `selected` is 0 out of reset and after each bus reset, and it rises only when a ROM command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: the link layer saw a reset on the bus |
| rx_valid | input | 1 | One-cycle pulse: a bit written by the master is on `rx_bit` |
| rx_bit | input | 1 | Bit written by the master |
| rd_req | input | 1 | One-cycle pulse: a read slot consumed the present `tx_bit` |
| serial_num | input | SERIAL_W | Serial number field of the identity |
| tx_bit | output | 1 | Value for the next read slot; 0 pulls the line low, 1 releases it |
| selected | output | 1 | High once a ROM command has completed; enables the memory layer |

## Verification
The bound checker examines, on every cycle, the rules that involve only local state. A bus reset must land in command reception with `selected` low. A mismatch in match or in search must lead to silence, and silence must hold until a reset. The complement slot of a search must invert the bit just answered. Lines that carry no identity data must stay released. `selected` may rise only after a bus event. Only the bench scenarios can show that the identity bits come out in the right order and carry the right CRC, that each command code is decoded as a complete LSB-first byte, and that a whole match or search ends in selection.

// File: rtl/rom_layer_pkg.sv
package rom_layer_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_READ,
      ST_MATCH,
      ST_S_TRUE,
      ST_S_CMP,
      ST_S_DIR,
      ST_SEL,
      ST_MUTE
   } rom_state_e;

   localparam logic [7:0] OP_READ_ID   = 8'h33;
   localparam logic [7:0] OP_MATCH_ID  = 8'h55;
   localparam logic [7:0] OP_SEARCH_ID = 8'hF0;
   localparam logic [7:0] OP_SKIP_ID   = 8'hCC;

   // one LSB-first step of the x^8+x^5+x^4+1 accumulator
   function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic din);
      logic fb;
      fb = acc[0] ^ din;
      crc8_step = {1'b0, acc[7:1]} ^ (fb ? 8'h8C : 8'h00);
   endfunction

endpackage

// File: rtl/rom_id_crc.sv
module rom_id_crc #(
   parameter int DATA_W = 56
) (
   input  logic [DATA_W-1:0] data,
   output logic [7:0]        crc
);
   import rom_layer_pkg::*;

   logic [7:0] chain [0:DATA_W];

   assign chain[0] = 8'h00;

   generate
      for (genvar g = 0; g < DATA_W; g++) begin : g_stage
         assign chain[g+1] = crc8_step(chain[g], data[g]);
      end
   endgenerate

   assign crc = chain[DATA_W];
endmodule

// File: rtl/rom_slot_cnt.sv
module rom_slot_cnt #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (inc)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rom_cmd_seq.sv
module rom_cmd_seq #(
   parameter int ID_W  = 64,
   parameter int CMD_W = 8,
   localparam int IDX_W = $clog2(ID_W)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_reset,
   input  logic                      rx_valid,
   input  logic                      rx_bit,
   input  logic                      rd_req,
   input  logic                      id_bit,
   input  logic [IDX_W-1:0]          idx,
   output logic                      cnt_clr,
   output logic                      cnt_inc,
   output rom_layer_pkg::rom_state_e state,
   output logic                      tx_bit,
   output logic                      selected
);
   import rom_layer_pkg::*;

   localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);
   localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);

   rom_state_e       st_q, st_d;
   logic [CMD_W-1:0] sh_q, cmd_full;
   logic             sh_en;

   assign cmd_full = {rx_bit, sh_q[CMD_W-1:1]};

   always_comb begin
      st_d    = st_q;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      sh_en   = 1'b0;
      if (bus_reset) begin
         st_d    = ST_CMD;
         cnt_clr = 1'b1;
      end else begin
         unique case (st_q)
            ST_CMD: if (rx_valid) begin
               sh_en = 1'b1;
               if (idx == CMD_LAST) begin
                  cnt_clr = 1'b1;
                  case (cmd_full)
                     OP_READ_ID:   st_d = ST_READ;
                     OP_MATCH_ID:  st_d = ST_MATCH;
                     OP_SEARCH_ID: st_d = ST_S_TRUE;
                     OP_SKIP_ID:   st_d = ST_SEL;
                     default:      st_d = ST_MUTE;
                  endcase
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_READ: if (rd_req) begin
               if (idx == ID_LAST) begin
                  st_d    = ST_SEL;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_MATCH: if (rx_valid) begin
               if (rx_bit != id_bit) begin
                  st_d = ST_MUTE;
               end else if (idx == ID_LAST) begin
                  st_d    = ST_SEL;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_S_TRUE: if (rd_req) st_d = ST_S_CMP;
            ST_S_CMP:  if (rd_req) st_d = ST_S_DIR;
            ST_S_DIR: if (rx_valid) begin
               if (rx_bit != id_bit) begin
                  st_d = ST_MUTE;
               end else if (idx == ID_LAST) begin
                  st_d    = ST_SEL;
                  cnt_clr = 1'b1;
               end else begin
                  st_d    = ST_S_TRUE;
                  cnt_inc = 1'b1;
               end
            end
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_CMD;
         sh_q <= '0;
      end else begin
         st_q <= st_d;
         if (bus_reset)  sh_q <= '0;
         else if (sh_en) sh_q <= cmd_full;
      end
   end

   always_comb begin
      unique case (st_q)
         ST_READ, ST_S_TRUE: tx_bit = id_bit;
         ST_S_CMP:           tx_bit = ~id_bit;
         default:            tx_bit = 1'b1;
      endcase
   end

   assign selected = (st_q == ST_SEL);
   assign state    = st_q;
endmodule

// File: rtl/rom_net_layer.sv
module rom_net_layer #(
   parameter logic [7:0] FAMILY_CODE = 8'h09,
   parameter int         SERIAL_W    = 48,
   parameter int         CMD_W       = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_reset,
   input  logic                rx_valid,
   input  logic                rx_bit,
   input  logic                rd_req,
   input  logic [SERIAL_W-1:0] serial_num,
   output logic                tx_bit,
   output logic                selected
);
   import rom_layer_pkg::*;

   localparam int FAM_W  = 8;
   localparam int CRC_W  = 8;
   localparam int BODY_W = FAM_W + SERIAL_W;
   localparam int ID_W   = BODY_W + CRC_W;
   localparam int IDX_W  = $clog2(ID_W);

   generate
      if (CMD_W != 8) begin : g_bad_cmd
         $error("rom_net_layer: command codes are 8 bits wide");
      end
      if (SERIAL_W < 1) begin : g_bad_serial
         $error("rom_net_layer: SERIAL_W must be positive");
      end
      if (ID_W > (1 << IDX_W)) begin : g_bad_idx
         $error("rom_net_layer: index width too small");
      end
   endgenerate

   logic [BODY_W-1:0] id_body;
   logic [CRC_W-1:0]  id_crc;
   logic [ID_W-1:0]   id_vec;
   logic [IDX_W-1:0]  idx;
   logic              id_bit;
   logic              cnt_clr, cnt_inc;
   rom_state_e        seq_state;

   assign id_body = {serial_num, FAMILY_CODE};
   assign id_vec  = {id_crc, id_body};
   assign id_bit  = id_vec[idx];

   rom_id_crc #(.DATA_W(BODY_W)) u_crc (
      .data (id_body),
      .crc  (id_crc)
   );

   rom_slot_cnt #(.W(IDX_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (idx)
   );

   rom_cmd_seq #(.ID_W(ID_W), .CMD_W(CMD_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_reset (bus_reset),
      .rx_valid  (rx_valid),
      .rx_bit    (rx_bit),
      .rd_req    (rd_req),
      .id_bit    (id_bit),
      .idx       (idx),
      .cnt_clr   (cnt_clr),
      .cnt_inc   (cnt_inc),
      .state     (seq_state),
      .tx_bit    (tx_bit),
      .selected  (selected)
   );
endmodule

// File: rtl/rom_net_layer_chk.sv
module rom_net_layer_chk (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_reset,
   input logic                      rx_valid,
   input logic                      rx_bit,
   input logic                      rd_req,
   input logic                      tx_bit,
   input logic                      selected,
   input logic                      cur_bit,
   input rom_layer_pkg::rom_state_e st
);
   import rom_layer_pkg::*;

   AST_RESET_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (st == ST_CMD && !selected)); // R8

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CMD || st == ST_MATCH || st == ST_MUTE || st == ST_SEL) |-> tx_bit); // R9

   AST_MATCH_MISS_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MATCH && rx_valid && !bus_reset && rx_bit != cur_bit) |=> st == ST_MUTE); // R4

   AST_SEARCH_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_S_TRUE && st == ST_S_CMP) |-> tx_bit == !$past(tx_bit)); // R5

   AST_SEARCH_MISS_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_S_DIR && rx_valid && !bus_reset && rx_bit != cur_bit) |=> st == ST_MUTE); // R5

   AST_MUTE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MUTE && !bus_reset) |=> st == ST_MUTE); // R7

   AST_SELECT_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(selected) |-> $past(rx_valid || rd_req)); // R10
endmodule

bind rom_net_layer rom_net_layer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_reset (bus_reset),
   .rx_valid  (rx_valid),
   .rx_bit    (rx_bit),
   .rd_req    (rd_req),
   .tx_bit    (tx_bit),
   .selected  (selected),
   .cur_bit   (id_bit),
   .st        (seq_state)
);

// File: tb/rom_net_layer_tb.sv
`timescale 1ns/1ps
module rom_net_layer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SER_W = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_reset = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, rd_req = 1'b0;
   logic [SER_W-1:0] serial_num = 48'h1A2B3C4D5E6F;
   logic tx_bit, selected;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   typedef struct { logic v; string req; } exp_t;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rom_net_layer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
      .rx_bit(rx_bit), .rd_req(rd_req), .serial_num(serial_num),
      .tx_bit(tx_bit), .selected(selected)
   );

   function automatic logic [63:0] make_id(input logic [SER_W-1:0] ser);
      logic [55:0] body;
      logic [7:0]  acc;
      body = {ser, 8'h09};
      acc = 8'h00;
      for (int i = 0; i < 56; i++) begin
         if (acc[0] ^ body[i]) acc = (acc >> 1) ^ 8'h8C;
         else                  acc = acc >> 1;
      end
      return {acc, body};
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // monitor: compares answered read slots against expected queue
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rd_req) begin
            exp_t it;
            n_checks++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL queue actual=%b expected=none", tx_bit);
            end else begin
               it = exp_q.pop_front();
               if (tx_bit !== it.v) begin
                  n_fail++;
                  $display("FAIL %s actual=%b expected=%b", it.req, tx_bit, it.v);
               end
            end
         end
      end
   end

   task automatic read_exp(input logic v, input string req);
      exp_t it;
      it.v = v; it.req = req;
      exp_q.push_back(it);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); rx_valid = 1'b1; rx_bit = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic pulse_reset();
      @(negedge clk); bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] idv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset selected", selected, 1'b0);
      chk("R9 reset tx", tx_bit, 1'b1);

      // read identity
      idv = make_id(serial_num);
      pulse_reset();
      send_byte(8'h33);
      chk("R1 read cmd not selected yet", selected, 1'b0);
      for (int i = 0; i < 64; i++) read_exp(idv[i], (i < 56) ? "R2 id bit" : "R3 crc bit");
      chk("R2 selected after read", selected, 1'b1);
      read_exp(1'b1, "R9 selected read");

      // full match
      pulse_reset();
      chk("R8 reset clears selected", selected, 1'b0);
      send_byte(8'h55);
      for (int i = 0; i < 63; i++) send_bit(idv[i]);
      chk("R10 match incomplete", selected, 1'b0);
      read_exp(1'b1, "R9 match read");
      send_bit(idv[63]);
      chk("R4 match selects", selected, 1'b1);

      // match with mismatch
      pulse_reset();
      send_byte(8'h55);
      for (int i = 0; i < 64; i++) send_bit((i == 20) ? ~idv[i] : idv[i]);
      chk("R4 mismatch not selected", selected, 1'b0);
      read_exp(1'b1, "R4 mismatch silent");

      // skip
      pulse_reset();
      for (int i = 0; i < 7; i++) send_bit(8'hCC >> i);
      chk("R1 seven bits not decoded", selected, 1'b0);
      send_bit(1'b1);
      chk("R6 skip selects", selected, 1'b1);

      // full search
      pulse_reset();
      send_byte(8'hF0);
      for (int i = 0; i < 64; i++) begin
         read_exp(idv[i], "R5 search true");
         read_exp(~idv[i], "R5 search complement");
         send_bit(idv[i]);
      end
      chk("R5 search selects", selected, 1'b1);

      // search dropout
      pulse_reset();
      send_byte(8'hF0);
      for (int i = 0; i < 6; i++) begin
         read_exp(idv[i], "R5 search true");
         read_exp(~idv[i], "R5 search complement");
         send_bit((i == 5) ? ~idv[i] : idv[i]);
      end
      read_exp(1'b1, "R5 dropped silent");
      read_exp(1'b1, "R5 dropped silent");
      chk("R5 dropout not selected", selected, 1'b0);

      // unknown command
      pulse_reset();
      send_byte(8'hA5);
      chk("R7 unknown not selected", selected, 1'b0);
      read_exp(1'b1, "R7 unknown silent");
      send_byte(8'hCC);
      chk("R7 later bits ignored", selected, 1'b0);

      // reset during identity read
      pulse_reset();
      send_byte(8'h33);
      for (int i = 0; i < 10; i++) read_exp(idv[i], "R2 id bit");
      pulse_reset();
      chk("R8 abort selected", selected, 1'b0);
      chk("R8 abort tx", tx_bit, 1'b1);
      send_byte(8'hCC);
      chk("R8 restarts reception", selected, 1'b1);

      // new serial: CRC recomputed
      serial_num = 48'h00A0B0C0D0E1;
      idv = make_id(serial_num);
      pulse_reset();
      send_byte(8'h33);
      for (int i = 0; i < 64; i++) read_exp(idv[i], (i < 56) ? "R2 id bit" : "R3 crc bit");
      chk("R2 selected second id", selected, 1'b1);

      repeat (4) @(negedge clk);
      chk("R9 queue drained", exp_q.size() == 0, 1'b1);
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule